// File: doc/BRIEF.md
# Machine-Check Error Logging Bank

This block records hardware errors for a processor-style system. It watches the bus for a failed cycle, which is signalled either by an external bus-check input or by an internal parity-check signal raised while parity checking is enabled. When such an error comes from a source that software has enabled, the block logs which source failed in a status register. It also latches the cycle-definition word of the failing cycle into a cycle-type register and sets that register's check bit.

Software reaches the three registers through a simple register port with an address, write data, a write strobe, a read strobe and combinational read data. Status is cleared by writing zero. Any non-zero write to status is refused and answered with a one-cycle fault pulse. Reading the cycle-type register with the read strobe returns its value and clears its check bit afterwards. A second error that arrives while the status record is still valid does not overwrite it. Instead it sets a sticky overflow bit. When an error arrives in the same cycle as a clearing access, the error wins.

Top module: `mc_err_bank`

## Requirements
- R1: After reset, all three registers read zero and `reg_fault` is low.
- R2: A write to address 0 (enable register) stores only the bits set in parameter `IMPL_MASK`. Unimplemented bits stay 0, and an error from a source whose bit is unimplemented is never logged.
- R3: An error is detected when `bus_chk` is high, or when `par_chk` and `par_en` are both high. `par_chk` alone is not an error.
- R4: A detected error whose source `err_src` has its enable bit clear changes no register.
- R5: An enabled error while status bit 63 (valid) is clear loads status, at address 1, with bit 63 set, bit 62 clear, bits 5:0 equal to `err_src` and all other bits zero. The new value is readable from the next cycle.
- R6: An enabled error while status is valid keeps the stored source and valid bit and sets bit 62 (overflow).
- R7: An enabled error loads the cycle-type register, at address 2, with `cyc_def` bits 63:1 and bit 0 (check bit) set to 1.
- R8: A read of address 2 with `reg_re` high returns the current value in that cycle and clears only bit 0 at the following edge.
- R9: Writing all zeros to address 1 clears the status register.
- R10: Writing any non-zero value to address 1 leaves status unchanged and raises `reg_fault` for exactly the one cycle after the write.
- R11: An enabled error in the same cycle as a zero write to status leaves a fresh record (valid set, overflow clear, new source). An enabled error in the same cycle as a clearing read of address 2 leaves the check bit set.
- R12: `reg_rdata` follows `reg_addr` combinationally. Address 3 reads zero. Writes to addresses 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select: 0 enable, 1 status, 2 cycle type |
| reg_wdata | input | 64 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe (side effect on address 2) |
| reg_rdata | output | 64 | Read data for `reg_addr` |
| reg_fault | output | 1 | One-cycle pulse after an illegal status write |
| bus_chk | input | 1 | External bus-check error |
| par_chk | input | 1 | Internal parity-check error |
| par_en | input | 1 | Parity checking enable |
| err_src | input | 6 | Index of the failing error source |
| cyc_def | input | 64 | Cycle-definition word of the current cycle |

## Verification
Directed cycles separate the two ways an error is detected. Parity check alone must leave status empty, and parity check together with parity enable must log a record. Each enabled error is also played against an empty and a full status, which tells a fresh record apart from overflow. Other directed cycles collide an error with a zero write or a clearing read to show that the error wins. Sources that are masked, or whose enable bits are unimplemented, must leave every register untouched. A long random run then mixes reads, writes (with zero and non-zero status data) and error pulses from all sources against a cycle-accurate model kept in the bench.

// File: rtl/mc_err_bank.sv
module mc_err_bank #(
  parameter int          DW        = 64,
  parameter logic [63:0] IMPL_MASK = 64'h0000_FFFF_0000_FFFF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            reg_addr,
  input  logic [DW-1:0]         reg_wdata,
  input  logic                  reg_we,
  input  logic                  reg_re,
  output logic [DW-1:0]         reg_rdata,
  output logic                  reg_fault,
  input  logic                  bus_chk,
  input  logic                  par_chk,
  input  logic                  par_en,
  input  logic [$clog2(DW)-1:0] err_src,
  input  logic [DW-1:0]         cyc_def
);
  localparam int SW    = $clog2(DW);
  localparam int VALID = DW - 1;
  localparam int OVF   = DW - 2;

  logic [DW-1:0] en_q, st_q, ty_q;
  logic          err, cap, st_clr, st_bad, ty_rd;

  assign err    = bus_chk | (par_chk & par_en);
  assign cap    = err & en_q[err_src];
  assign st_clr = reg_we & (reg_addr == 2'd1) & (reg_wdata == '0);
  assign st_bad = reg_we & (reg_addr == 2'd1) & (reg_wdata != '0);
  assign ty_rd  = reg_re & (reg_addr == 2'd2);

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = en_q;
      2'd1:    reg_rdata = st_q;
      2'd2:    reg_rdata = ty_q;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= '0;
      st_q      <= '0;
      ty_q      <= '0;
      reg_fault <= 1'b0;
    end else begin
      reg_fault <= st_bad;
      if (reg_we && reg_addr == 2'd0)
        en_q <= reg_wdata & IMPL_MASK[DW-1:0];
      if (cap) begin
        if (st_q[VALID] && !st_clr)
          st_q[OVF] <= 1'b1;
        else begin
          st_q         <= '0;
          st_q[VALID]  <= 1'b1;
          st_q[SW-1:0] <= err_src;
        end
        ty_q <= {cyc_def[DW-1:1], 1'b1};
      end else begin
        if (st_clr) st_q    <= '0;
        if (ty_rd)  ty_q[0] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mc_err_bank_chk.sv
module mc_err_bank_chk #(
  parameter int          DW        = 64,
  parameter logic [63:0] IMPL_MASK = 64'h0000_FFFF_0000_FFFF
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0]            reg_addr,
  input logic [DW-1:0]         reg_wdata,
  input logic                  reg_we,
  input logic                  reg_re,
  input logic                  reg_fault,
  input logic                  bus_chk,
  input logic                  par_chk,
  input logic                  par_en,
  input logic [$clog2(DW)-1:0] err_src,
  input logic [DW-1:0]         en_q,
  input logic [DW-1:0]         st_q,
  input logic [DW-1:0]         ty_q
);
  localparam int SW = $clog2(DW);
  logic hit;
  assign hit = (bus_chk | (par_chk & par_en)) & en_q[err_src];

  p_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_fault |-> $past(reg_we && reg_addr == 2'd1 && reg_wdata != '0));

  p_unimpl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q & ~IMPL_MASK[DW-1:0]) == '0);

  p_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !reg_we && !reg_re) |=> ($stable(st_q) && $stable(ty_q)));

  p_chk_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> ty_q[0]);

  p_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && st_q[DW-1] && !reg_we) |=> (st_q[DW-2] && $stable(st_q[SW-1:0])));

  p_rdclr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && reg_addr == 2'd2 && !hit) |=> !ty_q[0]);
endmodule

bind mc_err_bank mc_err_bank_chk #(.DW(DW), .IMPL_MASK(IMPL_MASK)) i_chk (.*);

// File: tb/test_mc_err_bank.sv
module test_mc_err_bank;
  localparam logic [63:0] MASK = 64'h0000_FFFF_0000_FFFF;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0, reg_rdata, cyc_def = '0;
  logic        reg_we = 1'b0, reg_re = 1'b0, reg_fault;
  logic        bus_chk = 1'b0, par_chk = 1'b0, par_en = 1'b0;
  logic [5:0]  err_src = '0;

  int checks = 0, errors = 0;
  logic [63:0] m_en = '0, m_st = '0, m_ty = '0;
  logic        m_fault = 1'b0;

  always #5 clk = ~clk;

  mc_err_bank #(.IMPL_MASK(MASK)) i_mc_err_bank (.*);

  function automatic logic [63:0] exp_rd(logic [1:0] a);
    case (a)
      2'd0: return m_en;
      2'd1: return m_st;
      2'd2: return m_ty;
      default: return 64'h0;
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag, logic [1:0] a, logic we, logic re, logic [63:0] wd,
                     logic bus, logic pc, logic pe, logic [5:0] src, logic [63:0] cd);
    logic e, cp, clr, bad;
    reg_addr = a; reg_we = we; reg_re = re; reg_wdata = wd;
    bus_chk = bus; par_chk = pc; par_en = pe; err_src = src; cyc_def = cd;
    #1 check(tag, reg_rdata, exp_rd(a));
    e   = bus | (pc & pe);
    cp  = e & m_en[src];
    clr = we && a == 2'd1 && wd == 64'h0;
    bad = we && a == 2'd1 && wd != 64'h0;
    @(posedge clk);
    m_fault = bad;
    if (we && a == 2'd0) m_en = wd & MASK;
    if (cp) begin
      m_st = (m_st[63] && !clr) ? (m_st | (64'h1 << 62)) : ((64'h1 << 63) | 64'(src));
      m_ty = {cd[63:1], 1'b1};
    end else begin
      if (clr) m_st = 64'h0;
      if (re && a == 2'd2) m_ty[0] = 1'b0;
    end
    @(negedge clk);
    reg_we = 1'b0; reg_re = 1'b0; bus_chk = 1'b0; par_chk = 1'b0; par_en = 1'b0;
    check({tag, " fault"}, {63'h0, reg_fault}, {63'h0, m_fault});
  endtask

  task automatic rd(string tag, logic [1:0] a);
    cyc(tag, a, 1'b0, 1'b0, 64'h0, 1'b0, 1'b0, 1'b0, 6'd0, 64'h0);
  endtask

  task automatic wr(string tag, logic [1:0] a, logic [63:0] d);
    cyc(tag, a, 1'b1, 1'b0, d, 1'b0, 1'b0, 1'b0, 6'd0, 64'h0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd("R1 enable", 2'd0); rd("R1 status", 2'd1); rd("R1 type", 2'd2);
    check("R1 values", {m_en, m_st}, 128'h0);
    // R2 implemented mask
    wr("R2 write", 2'd0, '1);
    rd("R2 readback", 2'd0);
    check("R2 mask", reg_rdata, MASK);
    // R3 parity check alone is not an error
    cyc("R3 par only", 2'd1, 0, 0, 0, 1'b0, 1'b1, 1'b0, 6'd1, 64'hAAAA_0000_1111_2222);
    rd("R3 no log", 2'd1);
    check("R3 status empty", reg_rdata, 64'h0);
    // R3 / R5 / R7 parity with enable
    cyc("R5 capture", 2'd1, 0, 0, 0, 1'b0, 1'b1, 1'b1, 6'd1, 64'hDEAD_BEEF_0000_1234);
    rd("R5 status", 2'd1);
    check("R5 record", reg_rdata, 64'h8000_0000_0000_0001);
    rd("R7 type", 2'd2);
    check("R7 latched", reg_rdata, 64'hDEAD_BEEF_0000_1235);
    // R6 overflow
    cyc("R6 second", 2'd0, 0, 0, 0, 1'b1, 1'b0, 1'b0, 6'd2, 64'h5555_0000_0000_0000);
    rd("R6 status", 2'd1);
    check("R6 overflow", reg_rdata, 64'hC000_0000_0000_0001);
    // R8 read clears check bit
    cyc("R8 read", 2'd2, 0, 1, 0, 0, 0, 0, 6'd0, 64'h0);
    rd("R8 after", 2'd2);
    check("R8 cleared", reg_rdata, 64'h5555_0000_0000_0000);
    // R10 illegal write
    wr("R10 bad write", 2'd1, 64'h10);
    check("R10 pulse", {63'h0, reg_fault}, 64'h1);
    rd("R10 pulse end", 2'd1);
    check("R10 unchanged", reg_rdata, 64'hC000_0000_0000_0001);
    // R9 clear
    wr("R9 clear", 2'd1, 64'h0);
    rd("R9 status", 2'd1);
    check("R9 empty", reg_rdata, 64'h0);
    // R4 masked source
    wr("R4 mask src3", 2'd0, MASK & ~(64'h1 << 3));
    cyc("R4 masked err", 2'd0, 0, 0, 0, 1'b1, 0, 0, 6'd3, 64'hFFFF);
    rd("R4 status", 2'd1); check("R4 no status", reg_rdata, 64'h0);
    rd("R4 type", 2'd2); check("R4 no type", reg_rdata, 64'h5555_0000_0000_0000);
    // R2 unimplemented source
    cyc("R2 unimpl err", 2'd0, 0, 0, 0, 1'b1, 0, 0, 6'd20, 64'hFFFF);
    rd("R2 status", 2'd1); check("R2 not logged", reg_rdata, 64'h0);
    // R11 collisions
    cyc("R11 fill", 2'd0, 0, 0, 0, 1'b1, 0, 0, 6'd5, 64'h1000);
    cyc("R11 clear+err", 2'd1, 1, 0, 64'h0, 1'b1, 0, 0, 6'd4, 64'h2000);
    rd("R11 status", 2'd1);
    check("R11 fresh", reg_rdata, 64'h8000_0000_0000_0004);
    cyc("R11 read+err", 2'd2, 0, 1, 0, 1'b1, 0, 0, 6'd6, 64'h3000);
    rd("R11 type", 2'd2);
    check("R11 chk kept", reg_rdata, 64'h3001);
    // R12 address 3 and read-only type
    wr("R12 write type", 2'd2, 64'h1234);
    wr("R12 write a3", 2'd3, 64'h5678);
    rd("R12 a3", 2'd3); check("R12 zero", reg_rdata, 64'h0);
    rd("R12 type", 2'd2); check("R12 type kept", reg_rdata, 64'h3001);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0]  a;
      logic [63:0] wd;
      a  = 2'($urandom_range(0, 3));
      wd = {$urandom, $urandom};
      if ($urandom_range(0, 2) == 0) wd = 64'h0;
      cyc("RND", a, $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1, wd,
          $urandom_range(0, 5) == 0, $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1,
          6'($urandom_range(0, 63)), {$urandom, $urandom});
    end
    finish_run();
  end
endmodule